// File: doc/BRIEF.md
# Cartridge ROM bank mapper

This block turns CPU writes into a small I/O register window into the upper address bits of a 2 MB external ROM store that holds many cartridge images. A bank-select register chooses one of eight banks. Each bank has its own 6-bit page register that names one of sixty-four 32K pages in the store. A two-bit size latch chooses between 32K cartridges and 16K cartridges. In 16K mode two images share one 32K page, and a half-select bit picks which one.

Every cartridge-window read offset is mapped combinationally to a 21-bit memory address. Writes are decoded only while the slot is enabled. Reset clears the bank selection and nothing else, so the page table and the size setting survive a machine reset.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write to address 0xFF40 loads data bits [2:0] as the selected bank. Asserting reset returns the selected bank to 0.
- R2: A write to 0xFF42 loads data bits [5:0] into the page register of bank 0. A write to 0xFF43+k, for k from 1 to 7 (that is 0xFF44 to 0xFF4A), loads the page register of bank k.
- R3: Reset leaves every page register and the size latch unchanged. All of them power up at 0.
- R4: When size bit 0 is 0 (32K mode), mem_addr_o = {page[selected], rom_off_i[14:0]}, and size bit 1 has no effect.
- R5: When size bit 0 is 1 (16K mode), mem_addr_o = {page[selected], size bit 1, rom_off_i[13:0]}. rom_off_i[14] is ignored, so the 16K image appears twice across the 32K window.
- R6: A write to 0xFF43 loads data bit 0 as the 16K-mode flag and data bit 1 as the half select. A value of 1 in bit 1 selects the upper 16K of the page.
- R7: Writes to 0xFF41 and to any address outside 0xFF40, 0xFF42 to 0xFF4A change no register.
- R8: No register changes unless slot_en_i and cpu_we_i are both 1 at the clock edge.
- R9: mem_addr_o follows rom_off_i with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the bank select only |
| slot_en_i | input | 1 | Slot enable; gates register writes |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| rom_off_i | input | 15 | Offset within the cartridge ROM window |
| mem_addr_o | output | 21 | External memory address |

## Verification
The bench uses the default parameters: eight banks, 6-bit pages and a 15-bit window. It sweeps every page value through every bank register and reads each one back through the address output. With distinct pages loaded, it then crosses all four size-latch codes with every bank and with offsets on both sides of the 16K boundary, which covers the aliasing and the half-select cases. Neighbouring addresses, gated writes and a reset taken mid-configuration are each followed by a full re-check of the mapping.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  // register offsets from the I/O base
  localparam int unsigned SelOfs    = 0;
  localparam int unsigned RsvdOfs   = 1;
  localparam int unsigned Page0Ofs  = 2;
  localparam int unsigned SizeOfs   = 3;
  localparam int unsigned PageNBase = 3;  // bank k (k>=1) at base+3+k

  typedef struct packed {
    logic upper_half;
    logic is_16k;
  } size_cfg_t;
endpackage

// File: rtl/cart_bank_decode.sv
module cart_bank_decode #(
  parameter int unsigned        CPU_AW    = 16,
  parameter int unsigned        NUM_BANKS = 8,
  parameter logic [CPU_AW-1:0]  IO_BASE   = 16'hFF40
) (
  input  logic                 slot_en_i,
  input  logic                 cpu_we_i,
  input  logic [CPU_AW-1:0]    cpu_addr_i,
  output logic                 sel_we_o,
  output logic                 size_we_o,
  output logic [NUM_BANKS-1:0] page_we_o
);
  import cart_bank_pkg::*;

  logic wr;
  assign wr = slot_en_i & cpu_we_i;

  assign sel_we_o  = wr && (cpu_addr_i == CPU_AW'(IO_BASE + SelOfs));
  assign size_we_o = wr && (cpu_addr_i == CPU_AW'(IO_BASE + SizeOfs));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_page_dec
    localparam logic [CPU_AW-1:0] PageAddr =
      (b == 0) ? CPU_AW'(IO_BASE + Page0Ofs) : CPU_AW'(IO_BASE + PageNBase + b);
    assign page_we_o[b] = wr && (cpu_addr_i == PageAddr);
  end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned PAGE_W    = 6,
  localparam int unsigned SEL_W    = $clog2(NUM_BANKS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sel_we_i,
  input  logic                      size_we_i,
  input  logic [NUM_BANKS-1:0]      page_we_i,
  input  logic [PAGE_W-1:0]         wdata_i,
  output logic [SEL_W-1:0]          sel_o,
  output cart_bank_pkg::size_cfg_t  size_o,
  output logic [PAGE_W-1:0]         page_o
);
  import cart_bank_pkg::*;

  logic [SEL_W-1:0]  sel_q;
  size_cfg_t         size_q = '0;
  logic [PAGE_W-1:0] page_arr [NUM_BANKS];

  // only the bank select sees reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (sel_we_i) sel_q <= wdata_i[SEL_W-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (size_we_i) size_q <= size_cfg_t'(wdata_i[1:0]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_page
    logic [PAGE_W-1:0] page_q = '0;
    always_ff @(posedge clk_i) begin
      if (page_we_i[b]) page_q <= wdata_i;
    end
    assign page_arr[b] = page_q;

    a_r2_page_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      page_we_i[b] |=> page_q == $past(wdata_i));
  end

  assign sel_o  = sel_q;
  assign size_o = size_q;
  assign page_o = page_arr[sel_q];

  a_r1_sel_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> sel_q == $past(wdata_i[SEL_W-1:0]));
  a_r7_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_we_i, size_we_i, page_we_i}));
endmodule

// File: rtl/cart_bank_addr.sv
module cart_bank_addr #(
  parameter int unsigned  PAGE_W = 6,
  parameter int unsigned  OFF_W  = 15,
  localparam int unsigned ADDR_W = PAGE_W + OFF_W
) (
  input  logic [PAGE_W-1:0]         page_i,
  input  cart_bank_pkg::size_cfg_t  size_i,
  input  logic [OFF_W-1:0]          off_i,
  output logic [ADDR_W-1:0]         addr_o
);
  logic [OFF_W-1:0] low;

  // 16K mode: top offset bit replaced by half select, image aliases
  always_comb begin
    low = off_i;
    if (size_i.is_16k) low[OFF_W-1] = size_i.upper_half;
  end

  assign addr_o = {page_i, low};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int unsigned        CPU_AW    = 16,
  parameter int unsigned        CPU_DW    = 8,
  parameter int unsigned        NUM_BANKS = 8,
  parameter int unsigned        PAGE_W    = 6,
  parameter int unsigned        OFF_W     = 15,
  parameter logic [CPU_AW-1:0]  IO_BASE   = 16'hFF40,
  localparam int unsigned       ADDR_W    = PAGE_W + OFF_W,
  localparam int unsigned       SEL_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_en_i,
  input  logic              cpu_we_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [CPU_DW-1:0] cpu_data_i,
  input  logic [OFF_W-1:0]  rom_off_i,
  output logic [ADDR_W-1:0] mem_addr_o
);
  import cart_bank_pkg::*;

  logic                 sel_we, size_we;
  logic [NUM_BANKS-1:0] page_we;
  logic [SEL_W-1:0]     sel_w;
  size_cfg_t            size_w;
  logic [PAGE_W-1:0]    page_w;
  logic                 unused_data;

  assign unused_data = ^cpu_data_i;

  cart_bank_decode #(
    .CPU_AW(CPU_AW), .NUM_BANKS(NUM_BANKS), .IO_BASE(IO_BASE)
  ) u_decode (
    .slot_en_i (slot_en_i),
    .cpu_we_i  (cpu_we_i),
    .cpu_addr_i(cpu_addr_i),
    .sel_we_o  (sel_we),
    .size_we_o (size_we),
    .page_we_o (page_we)
  );

  cart_bank_regs #(
    .NUM_BANKS(NUM_BANKS), .PAGE_W(PAGE_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_we_i (sel_we),
    .size_we_i(size_we),
    .page_we_i(page_we),
    .wdata_i  (cpu_data_i[PAGE_W-1:0]),
    .sel_o    (sel_w),
    .size_o   (size_w),
    .page_o   (page_w)
  );

  cart_bank_addr #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W)
  ) u_addr (
    .page_i(page_w),
    .size_i(size_w),
    .off_i (rom_off_i),
    .addr_o(mem_addr_o)
  );

  a_r8_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slot_en_i && cpu_we_i) |=> $stable(sel_w) && $stable(size_w) && $stable(page_w));
  a_r7_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_en_i && cpu_we_i && cpu_addr_i == CPU_AW'(IO_BASE + RsvdOfs))
      |=> $stable(sel_w) && $stable(size_w) && $stable(page_w));
  a_r4_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !size_w.is_16k |-> mem_addr_o[OFF_W-1:0] == rom_off_i);
  a_r5_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_w.is_16k |-> mem_addr_o[OFF_W-1] == size_w.upper_half
                      && mem_addr_o[OFF_W-2:0] == rom_off_i[OFF_W-2:0]);
endmodule

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slot_en = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [14:0] off = '0;
  logic [20:0] mem_addr;

  int total = 0;
  int bad = 0;
  logic [5:0] m_page [8];
  logic [2:0] m_sel = '0;
  logic [1:0] m_size = '0;

  always #4 clk = ~clk;

  cart_bank_mapper u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .slot_en_i(slot_en), .cpu_we_i(we),
    .cpu_addr_i(addr), .cpu_data_i(data), .rom_off_i(off), .mem_addr_o(mem_addr)
  );

  function automatic logic [20:0] expect_addr(input logic [14:0] o);
    if (m_size[0]) return {m_page[m_sel], m_size[1], o[13:0]};
    return {m_page[m_sel], o};
  endfunction

  task automatic chk(input logic [14:0] o, input string tag);
    off = o;
    #1;
    total++;
    if (mem_addr !== expect_addr(o)) begin
      bad++;
      $display("FAIL %s: off=%h got=%h exp=%h", tag, o, mem_addr, expect_addr(o));
    end
  endtask

  // model update follows R1, R2, R6 and R8
  task automatic wr(input logic [15:0] a, input logic [7:0] d,
                    input logic en = 1'b1, input logic w = 1'b1);
    @(negedge clk);
    addr = a; data = d; slot_en = en; we = w;
    @(negedge clk);
    we = 1'b0; slot_en = 1'b0;
    if (en && w) begin
      if (a == 16'hFF40) m_sel = d[2:0];
      else if (a == 16'hFF42) m_page[0] = d[5:0];
      else if (a == 16'hFF43) m_size = d[1:0];
      else if (a >= 16'hFF44 && a <= 16'hFF4A) m_page[a - 16'hFF43] = d[5:0];
    end
  endtask

  task automatic chk_all(input string tag);
    for (int b = 0; b < 8; b++) begin
      wr(16'hFF40, 8'(b));
      chk(15'h0000, tag);
      chk(15'h7FFF, tag);
      chk(15'h4A5A, tag);
    end
  endtask

  function automatic logic [15:0] page_addr(input int b);
    return (b == 0) ? 16'hFF42 : 16'(16'hFF43 + b);
  endfunction

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) m_page[b] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R3 power-up zero pages, R1 reset select 0, R9 combinational path
    chk(15'h1234, "R3");
    chk(15'h7FFF, "R9");
    wr(16'hFF42, 8'h05);
    wr(16'hFF46, 8'h09);
    chk(15'h0042, "R1");

    // R2 every page value into every bank, read back through the output
    for (int b = 0; b < 8; b++) begin
      wr(16'hFF40, {5'b10101, 3'(b)});
      for (int p = 0; p < 64; p++) begin
        wr(page_addr(b), {2'b11, 6'(p)});
        chk(15'(p * 389), "R2");
      end
    end

    // R4 R5 R6 distinct pages, all size codes, offsets around 16K
    for (int b = 0; b < 8; b++) wr(page_addr(b), 8'(7 * b + 3));
    for (int m = 0; m < 4; m++) begin
      wr(16'hFF43, {6'b111111, 2'(m)});
      for (int b = 0; b < 8; b++) begin
        wr(16'hFF40, 8'(b));
        chk(15'h0000, m[0] ? "R5" : "R4");
        chk(15'h3FFF, m[0] ? "R5" : "R4");
        chk(15'h4000, m[0] ? "R5" : "R6");
        chk(15'h7FFF, m[0] ? "R5" : "R6");
        chk(15'h2C3D, "R6");
        chk(15'h6C3D, "R5");
      end
    end

    // R7 reserved and neighbouring addresses
    wr(16'hFF43, 8'h03);
    wr(16'hFF40, 8'h02);
    wr(16'hFF41, 8'hFF);
    wr(16'hFF41, 8'h00);
    wr(16'hFF4B, 8'h3F);
    wr(16'hFF3F, 8'h3F);
    wr(16'hBF42, 8'h11);
    wr(16'h7F40, 8'h05);
    wr(16'hFF50, 8'h01);
    chk(15'h1111, "R7");
    chk_all("R7");

    // R8 gated writes
    wr(16'hFF43, 8'h00);
    wr(16'hFF40, 8'h04);
    for (int b = 0; b < 8; b++) begin
      wr(page_addr(b), 8'h2A, 1'b0, 1'b1);
      wr(page_addr(b), 8'h15, 1'b1, 1'b0);
    end
    wr(16'hFF40, 8'h01, 1'b0, 1'b1);
    wr(16'hFF43, 8'h01, 1'b1, 1'b0);
    wr(16'hFF43, 8'h03, 1'b0, 1'b1);
    chk(15'h5555, "R8");
    chk_all("R8");

    // R3 R1 reset mid-configuration
    wr(16'hFF43, 8'h03);
    wr(16'hFF40, 8'h05);
    @(negedge clk);
    rst_ni = 1'b0;
    m_sel = '0;
    #1;
    chk(15'h4321, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
    chk(15'h0123, "R3");
    chk_all("R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule